// File: doc/BRIEF.md
# Uncached Access Buffer with Request Merging

This block sits between the load/store units and a bus port for uncached traffic. Each request names its kind (load or store), whether its target is non-cacheable memory or strongly ordered device space, an address, a byte mask, store data and a requester id. In the cycle after a request the buffer reports its decision. It can take a free slot, fold the request into a pending slot for the same 8-byte line, queue it behind a slot for that line that is already issued, or refuse it. An accepted request gets back its own requester id paired with the buffer's slot id. The completion that follows names only the slot id, so every requester that was merged into one slot retires on the same completion.

Slots that are ready to go are sent to the bus oldest first over a simple acquire handshake. A slot counts as in flight only once that handshake completes. A grant naming the slot frees it and wakes any slot that was queued behind it. A lookup port gives a younger load byte-wise forwarding from store slots for a line, and bytes of a queued slot win over bytes of the older slot that is in flight.

Top module: `ucb_top`

## Requirements
- R1: A request whose line matches no occupied slot, with a free slot and a legal mask, is accepted one cycle later with ack_mid equal to req_mid and ack_sid equal to the lowest-numbered free slot.
- R2: With every slot occupied, a request to a new line is answered with ack_valid=1 and ack_accept=0.
- R3: A non-cacheable store to the line of a pending, unselected non-cacheable store slot is merged. The ack returns that slot's id, the issued mask is the union of both masks, later store bytes replace earlier ones, and acq_addr carries the lowest set byte of the union as its offset.
- R4: A non-cacheable load to the line of a pending, unselected non-cacheable load slot is merged into that slot, and the union mask is issued once.
- R5: A request whose line matches any occupied slot is refused when either side targets device space or when the kinds differ (load against store).
- R6: A byte mask is legal only when it is a contiguous run of 1, 2, 4 or 8 bytes starting at a multiple of its size. A new request's run must start at its address offset. A request is refused if its own mask is illegal or if the merged union would be illegal.
- R7: A compatible request to the line of a slot that is on the acquire port or in flight gets a new slot that is not issued until the older slot is granted, and is issued after that grant.
- R8: While acq_valid=1 and acq_ready=0, the acquire port holds the same slot id, mask and address.
- R9: A grant for an in-flight slot gives rsp_valid=1 with that rsp_sid and rsp_data one cycle later, and frees the slot for reuse.
- R10: A lookup returns, one cycle later, the union of store bytes held for the line, with bytes of a not-yet-issued slot overriding those of the in-flight slot.
- R11: Among slots ready to issue, the one accepted earliest is put on the acquire port first, whatever its slot number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_nc | input | 1 | 1 for non-cacheable memory, 0 for device space |
| req_addr | input | ADDR_W | Byte address |
| req_mask | input | DATA_W/8 | Byte enables within the 8-byte line |
| req_data | input | DATA_W | Store data, line-aligned |
| req_mid | input | ID_W | Requester id |
| ack_valid | output | 1 | Decision for the previous cycle's request |
| ack_accept | output | 1 | 1 accepted, 0 refused |
| ack_mid | output | ID_W | Requester id echoed |
| ack_sid | output | log2(NUM_ENT) | Slot that holds the request |
| acq_valid | output | 1 | Slot offered to the bus |
| acq_ready | input | 1 | Bus takes the offered slot |
| acq_store | output | 1 | Kind of the offered slot |
| acq_addr | output | ADDR_W | Line address with offset of lowest enabled byte |
| acq_mask | output | DATA_W/8 | Byte mask of the offered slot |
| acq_data | output | DATA_W | Store data of the offered slot |
| acq_sid | output | log2(NUM_ENT) | Id of the offered slot |
| gnt_valid | input | 1 | Bus completes a slot |
| gnt_sid | input | log2(NUM_ENT) | Slot completed |
| gnt_data | input | DATA_W | Load data returned |
| rsp_valid | output | 1 | Completion to requesters |
| rsp_sid | output | log2(NUM_ENT) | Slot id of the completion |
| rsp_data | output | DATA_W | Data of the completion |
| fwd_valid | input | 1 | Forwarding lookup present |
| fwd_line | input | ADDR_W-log2(DATA_W/8) | Line looked up |
| fwd_hit | output | DATA_W/8 | Bytes found in store slots |
| fwd_data | output | DATA_W | Forwarded bytes |

## Verification
Most wrong internal state shows at the ports within one or two cycles. A slot marked wrongly as issued or waiting shows up as a request that should have merged but instead comes back with a new ack_sid. A wake-up that never happens shows up as acq_valid that stays low after a grant, and a broken age order as the wrong acq_sid two cycles after a handshake. Corrupted merge bookkeeping appears as a wrong acq_mask, data byte or address offset the first time the slot is offered. A bad forwarding priority appears in the lookup result one cycle after the lookup.

// File: rtl/ucb_pkg.sv
package ucb_pkg;
  typedef enum logic [1:0] {
    ST_FREE,
    ST_PEND,
    ST_WAIT,
    ST_INFL
  } slot_st_e;

  typedef enum logic [1:0] {
    DEC_REJECT,
    DEC_ALLOC,
    DEC_ALLOC_WAIT,
    DEC_MERGE
  } req_dec_e;
endpackage

// File: rtl/ucb_age_pick.sv
module ucb_age_pick #(
  parameter int N   = 4,
  parameter int IDX = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_valid,
  input  logic [IDX-1:0] alloc_idx,
  input  logic [N-1:0]   cand,
  output logic           pick_valid,
  output logic [IDX-1:0] pick_idx
);
  // older_q[a][b] set: slot a was accepted before slot b
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < N; a++) older_q[a] <= '0;
    end else if (alloc_valid) begin
      for (int a = 0; a < N; a++) begin
        if (IDX'(a) == alloc_idx) older_q[a] <= '0;
        else older_q[a][alloc_idx] <= 1'b1;
      end
    end
  end

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int a = 0; a < N; a++) begin
      logic beaten;
      beaten = 1'b0;
      for (int b = 0; b < N; b++)
        if (b != a && cand[b] && older_q[b][a]) beaten = 1'b1;
      if (cand[a] && !beaten && !pick_valid) begin
        pick_valid = 1'b1;
        pick_idx   = IDX'(a);
      end
    end
  end
endmodule

// File: rtl/ucb_fwd.sv
module ucb_fwd #(
  parameter int N      = 4,
  parameter int BYTES  = 8,
  parameter int LINE_W = 29
) (
  input  logic [LINE_W-1:0]  look_line,
  input  logic [N-1:0]       old_src,
  input  logic [N-1:0]       new_src,
  input  logic [LINE_W-1:0]  ent_line [N],
  input  logic [BYTES-1:0]   ent_mask [N],
  input  logic [8*BYTES-1:0] ent_data [N],
  output logic [BYTES-1:0]   hit,
  output logic [8*BYTES-1:0] data
);
  always_comb begin
    hit  = '0;
    data = '0;
    // first pass: issued slot, second pass: queued slot overrides it
    for (int pass = 0; pass < 2; pass++) begin
      for (int e = 0; e < N; e++) begin
        logic use_e;
        use_e = ((pass == 0) ? old_src[e] : new_src[e]) && (ent_line[e] == look_line);
        for (int b = 0; b < BYTES; b++) begin
          if (use_e && ent_mask[e][b]) begin
            hit[b]          = 1'b1;
            data[8*b +: 8]  = ent_data[e][8*b +: 8];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ucb_top.sv
module ucb_top
  import ucb_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int ID_W    = 4,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int SID_W  = $clog2(NUM_ENT),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_nc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTES-1:0]  req_mask,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ID_W-1:0]   req_mid,
  output logic              ack_valid,
  output logic              ack_accept,
  output logic [ID_W-1:0]   ack_mid,
  output logic [SID_W-1:0]  ack_sid,
  output logic              acq_valid,
  input  logic              acq_ready,
  output logic              acq_store,
  output logic [ADDR_W-1:0] acq_addr,
  output logic [BYTES-1:0]  acq_mask,
  output logic [DATA_W-1:0] acq_data,
  output logic [SID_W-1:0]  acq_sid,
  input  logic              gnt_valid,
  input  logic [SID_W-1:0]  gnt_sid,
  input  logic [DATA_W-1:0] gnt_data,
  output logic              rsp_valid,
  output logic [SID_W-1:0]  rsp_sid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fwd_valid,
  input  logic [LINE_W-1:0] fwd_line,
  output logic [BYTES-1:0]  fwd_hit,
  output logic [DATA_W-1:0] fwd_data
);

  // ---------------- mask helpers ----------------
  function automatic logic run_ok(input logic [BYTES-1:0] m, input logic [OFF_W-1:0] off);
    logic             ok;
    logic [BYTES-1:0] pat;
    ok = 1'b0;
    for (int s = 1; s <= BYTES; s = s * 2) begin
      for (int p = 0; p < BYTES; p += s) begin
        pat = ({BYTES{1'b1}} >> (BYTES - s)) << p;
        if (m == pat && p == int'(off)) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  function automatic logic [OFF_W-1:0] first_byte(input logic [BYTES-1:0] m);
    logic [OFF_W-1:0] idx;
    idx = '0;
    for (int b = BYTES - 1; b >= 0; b--) if (m[b]) idx = OFF_W'(b);
    return idx;
  endfunction

  // ---------------- slot storage ----------------
  slot_st_e          st_q    [NUM_ENT];
  logic              store_q [NUM_ENT];
  logic              nc_q    [NUM_ENT];
  logic [LINE_W-1:0] line_q  [NUM_ENT];
  logic [OFF_W-1:0]  off_q   [NUM_ENT];
  logic [BYTES-1:0]  mask_q  [NUM_ENT];
  logic [DATA_W-1:0] data_q  [NUM_ENT];

  logic              acq_q;
  logic [SID_W-1:0]  sel_q;

  // ---------------- request decision ----------------
  logic [LINE_W-1:0] req_line;
  logic [NUM_ENT-1:0] hit_v, open_v, busy_v, compat_v;
  logic              has_open, has_free, req_ok;
  logic [SID_W-1:0]  tgt, fidx;
  logic [BYTES-1:0]  merged_mask;
  req_dec_e          dec;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_ok   = run_ok(req_mask, req_addr[OFF_W-1:0]);

  always_comb begin
    has_open = 1'b0;
    has_free = 1'b0;
    tgt      = '0;
    fidx     = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      logic on_port, freeing;
      on_port     = acq_q && (sel_q == SID_W'(i));
      freeing     = gnt_valid && (gnt_sid == SID_W'(i)) && (st_q[i] == ST_INFL);
      hit_v[i]    = (st_q[i] != ST_FREE) && (line_q[i] == req_line);
      compat_v[i] = nc_q[i] && req_nc && (store_q[i] == req_store);
      open_v[i]   = hit_v[i] && (st_q[i] != ST_INFL) && !on_port;
      busy_v[i]   = hit_v[i] && ((st_q[i] == ST_INFL) || on_port) && !freeing;
      if (open_v[i] && !has_open) begin
        has_open = 1'b1;
        tgt      = SID_W'(i);
      end
      if (st_q[i] == ST_FREE && !has_free) begin
        has_free = 1'b1;
        fidx     = SID_W'(i);
      end
    end
    merged_mask = mask_q[tgt] | req_mask;
    dec = DEC_REJECT;
    if (req_valid && req_ok && ((hit_v & ~compat_v) == '0)) begin
      if (has_open) begin
        if (run_ok(merged_mask, first_byte(merged_mask))) dec = DEC_MERGE;
      end else if (has_free) begin
        dec = (|busy_v) ? DEC_ALLOC_WAIT : DEC_ALLOC;
      end
    end
  end

  // ---------------- issue order ----------------
  logic [NUM_ENT-1:0] ready_v;
  logic               pick_valid;
  logic [SID_W-1:0]   pick_idx;
  logic               alloc_now;

  assign alloc_now = (dec == DEC_ALLOC) || (dec == DEC_ALLOC_WAIT);

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ready
      assign ready_v[g] = (st_q[g] == ST_PEND);
    end
  endgenerate

  ucb_age_pick #(.N(NUM_ENT), .IDX(SID_W)) u_age (
    .clk        (clk),
    .rst        (rst),
    .alloc_valid(alloc_now),
    .alloc_idx  (fidx),
    .cand       (ready_v),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  // ---------------- slot state update ----------------
  logic acq_fire;
  logic gnt_live;
  assign acq_fire = acq_q && acq_ready;
  assign gnt_live = gnt_valid && (st_q[gnt_sid] == ST_INFL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) st_q[i] <= ST_FREE;
    end else begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (gnt_live && gnt_sid == SID_W'(i))
          st_q[i] <= ST_FREE;
        else if (gnt_live && st_q[i] == ST_WAIT && line_q[i] == line_q[gnt_sid])
          st_q[i] <= ST_PEND;
        if (acq_fire && sel_q == SID_W'(i))
          st_q[i] <= ST_INFL;
        if (alloc_now && fidx == SID_W'(i))
          st_q[i] <= (dec == DEC_ALLOC_WAIT) ? ST_WAIT : ST_PEND;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (alloc_now && fidx == SID_W'(i)) begin
        store_q[i] <= req_store;
        nc_q[i]    <= req_nc;
        line_q[i]  <= req_line;
        off_q[i]   <= req_addr[OFF_W-1:0];
        mask_q[i]  <= req_mask;
        data_q[i]  <= req_data;
      end else if (dec == DEC_MERGE && tgt == SID_W'(i)) begin
        mask_q[i] <= merged_mask;
        off_q[i]  <= first_byte(merged_mask);
        for (int b = 0; b < BYTES; b++)
          if (req_store && req_mask[b]) data_q[i][8*b +: 8] <= req_data[8*b +: 8];
      end
    end
  end

  // ---------------- acquire port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      acq_q <= 1'b0;
      sel_q <= '0;
    end else if (acq_fire) begin
      acq_q <= 1'b0;
    end else if (!acq_q && pick_valid) begin
      acq_q <= 1'b1;
      sel_q <= pick_idx;
    end
  end

  assign acq_valid = acq_q;
  assign acq_sid   = sel_q;
  assign acq_store = store_q[sel_q];
  assign acq_addr  = {line_q[sel_q], off_q[sel_q]};
  assign acq_mask  = mask_q[sel_q];
  assign acq_data  = data_q[sel_q];

  // ---------------- ack and completion ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid  <= 1'b0;
      ack_accept <= 1'b0;
      ack_mid    <= '0;
      ack_sid    <= '0;
      rsp_valid  <= 1'b0;
      rsp_sid    <= '0;
      rsp_data   <= '0;
    end else begin
      ack_valid  <= req_valid;
      ack_accept <= (dec != DEC_REJECT);
      ack_mid    <= req_mid;
      ack_sid    <= (dec == DEC_MERGE) ? tgt : fidx;
      rsp_valid  <= gnt_live;
      rsp_sid    <= gnt_sid;
      rsp_data   <= gnt_data;
    end
  end

  // ---------------- forwarding ----------------
  logic [NUM_ENT-1:0] old_src, new_src;
  logic [BYTES-1:0]   fwd_hit_c;
  logic [DATA_W-1:0]  fwd_data_c;

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_fsrc
      assign old_src[g] = store_q[g] && (st_q[g] == ST_INFL);
      assign new_src[g] = store_q[g] && ((st_q[g] == ST_PEND) || (st_q[g] == ST_WAIT));
    end
  endgenerate

  ucb_fwd #(.N(NUM_ENT), .BYTES(BYTES), .LINE_W(LINE_W)) u_fwd (
    .look_line(fwd_line),
    .old_src  (old_src),
    .new_src  (new_src),
    .ent_line (line_q),
    .ent_mask (mask_q),
    .ent_data (data_q),
    .hit      (fwd_hit_c),
    .data     (fwd_data_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !fwd_valid) begin
      fwd_hit  <= '0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= fwd_hit_c;
      fwd_data <= fwd_data_c;
    end
  end
endmodule

// File: rtl/ucb_chk.sv
module ucb_chk #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3,
  parameter int SID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             ack_valid,
  input logic             acq_valid,
  input logic             acq_ready,
  input logic [SID_W-1:0] acq_sid,
  input logic [BYTES-1:0] acq_mask,
  input logic [OFF_W-1:0] acq_off,
  input logic             gnt_valid,
  input logic [SID_W-1:0] gnt_sid,
  input logic             rsp_valid,
  input logic [SID_W-1:0] rsp_sid,
  input logic             fwd_valid,
  input logic [BYTES-1:0] fwd_hit
);
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ack_valid); // R1

  AST_ACQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (acq_valid && !acq_ready) |=> (acq_valid && $stable(acq_sid) && $stable(acq_mask) && $stable(acq_off))); // R8

  AST_ACQ_MASK_RUN: assert property (@(posedge clk) disable iff (rst)
    acq_valid |-> $onehot($countones(acq_mask))); // R6

  AST_ACQ_OFF_FIRST: assert property (@(posedge clk) disable iff (rst)
    acq_valid |-> (((acq_mask >> acq_off) & BYTES'(1)) == BYTES'(1))); // R3

  AST_RSP_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(gnt_valid) && rsp_sid == $past(gnt_sid))); // R9

  AST_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fwd_valid |=> (fwd_hit == '0)); // R10
endmodule

bind ucb_top ucb_chk #(.BYTES(BYTES), .OFF_W(OFF_W), .SID_W(SID_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .ack_valid(ack_valid),
  .acq_valid(acq_valid),
  .acq_ready(acq_ready),
  .acq_sid  (acq_sid),
  .acq_mask (acq_mask),
  .acq_off  (acq_addr[OFF_W-1:0]),
  .gnt_valid(gnt_valid),
  .gnt_sid  (gnt_sid),
  .rsp_valid(rsp_valid),
  .rsp_sid  (rsp_sid),
  .fwd_valid(fwd_valid),
  .fwd_hit  (fwd_hit)
);

// File: tb/ucb_top_tb.sv
module ucb_top_tb;
  localparam int NUM_ENT = 4;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 64;
  localparam int ID_W    = 4;
  localparam int BYTES   = DATA_W / 8;
  localparam int SID_W   = 2;
  localparam int LINE_W  = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              req_valid = 0, req_store = 0, req_nc = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BYTES-1:0]  req_mask = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic [ID_W-1:0]   req_mid = '0;
  logic              ack_valid, ack_accept;
  logic [ID_W-1:0]   ack_mid;
  logic [SID_W-1:0]  ack_sid;
  logic              acq_valid, acq_store;
  logic              acq_ready = 0;
  logic [ADDR_W-1:0] acq_addr;
  logic [BYTES-1:0]  acq_mask;
  logic [DATA_W-1:0] acq_data;
  logic [SID_W-1:0]  acq_sid;
  logic              gnt_valid = 0;
  logic [SID_W-1:0]  gnt_sid = '0;
  logic [DATA_W-1:0] gnt_data = '0;
  logic              rsp_valid;
  logic [SID_W-1:0]  rsp_sid;
  logic [DATA_W-1:0] rsp_data;
  logic              fwd_valid = 0;
  logic [LINE_W-1:0] fwd_line = '0;
  logic [BYTES-1:0]  fwd_hit;
  logic [DATA_W-1:0] fwd_data;

  ucb_top #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_store(req_store), .req_nc(req_nc), .req_addr(req_addr),
    .req_mask(req_mask), .req_data(req_data), .req_mid(req_mid),
    .ack_valid(ack_valid), .ack_accept(ack_accept), .ack_mid(ack_mid), .ack_sid(ack_sid),
    .acq_valid(acq_valid), .acq_ready(acq_ready), .acq_store(acq_store), .acq_addr(acq_addr),
    .acq_mask(acq_mask), .acq_data(acq_data), .acq_sid(acq_sid),
    .gnt_valid(gnt_valid), .gnt_sid(gnt_sid), .gnt_data(gnt_data),
    .rsp_valid(rsp_valid), .rsp_sid(rsp_sid), .rsp_data(rsp_data),
    .fwd_valid(fwd_valid), .fwd_line(fwd_line), .fwd_hit(fwd_hit), .fwd_data(fwd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic             got_acc;
  logic [SID_W-1:0] got_sid;
  logic [ID_W-1:0]  got_mid;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic st, input logic nc, input logic [31:0] addr,
                      input logic [7:0] mask, input logic [63:0] data, input logic [3:0] mid);
    req_valid = 1; req_store = st; req_nc = nc; req_addr = addr;
    req_mask = mask; req_data = data; req_mid = mid;
    @(negedge clk);
    got_acc = ack_accept; got_sid = ack_sid; got_mid = ack_mid;
    check("ack_valid", 64'(ack_valid), 64'd1);
    req_valid = 0;
  endtask

  task automatic fire();
    acq_ready = 1;
    @(negedge clk);
    acq_ready = 0;
    @(negedge clk);
  endtask

  task automatic grant(input logic [SID_W-1:0] sid, input logic [63:0] data);
    gnt_valid = 1; gnt_sid = sid; gnt_data = data;
    @(negedge clk);
    gnt_valid = 0;
    check("R9 rsp_valid", 64'(rsp_valid), 64'd1);
    check("R9 rsp_sid", 64'(rsp_sid), 64'(sid));
    check("R9 rsp_data", rsp_data, data);
  endtask

  task automatic drain();
    for (int k = 0; k < 12; k++) begin
      if (acq_valid) begin
        logic [SID_W-1:0] s;
        s = acq_sid;
        acq_ready = 1;
        @(negedge clk);
        acq_ready = 0;
        grant(s, 64'h0);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    check("R1 reset ack_valid", 64'(ack_valid), 64'd0);
    check("R1 reset acq_valid", 64'(acq_valid), 64'd0);
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10 reset fwd_hit", 64'(fwd_hit), 64'd0);
  endtask

  task automatic t_store_merge_and_wait();
    send(1, 1, 32'h1000, 8'h01, 64'h11, 4'd1);
    check("R1 accept", 64'(got_acc), 64'd1);
    check("R1 sid", 64'(got_sid), 64'd0);
    check("R1 mid", 64'(got_mid), 64'd1);
    send(1, 1, 32'h1001, 8'h02, 64'h2200, 4'd2);
    check("R3 merge accept", 64'(got_acc), 64'd1);
    check("R3 merge sid", 64'(got_sid), 64'd0);
    check("R3 merge mid", 64'(got_mid), 64'd2);
    check("R3 acq_valid", 64'(acq_valid), 64'd1);
    check("R3 acq_mask", 64'(acq_mask), 64'h03);
    check("R3 acq_addr", 64'(acq_addr), 64'h1000);
    check("R3 acq_data", 64'(acq_data[15:0]), 64'h2211);
    @(negedge clk);
    check("R8 held sid", 64'(acq_sid), 64'd0);
    check("R8 held mask", 64'(acq_mask), 64'h03);
    send(1, 1, 32'h1001, 8'h02, 64'h9900, 4'd3);
    check("R7 queued accept", 64'(got_acc), 64'd1);
    check("R7 queued sid", 64'(got_sid), 64'd1);
    fire();
    check("R7 not issued", 64'(acq_valid), 64'd0);
    @(negedge clk);
    @(negedge clk);
    check("R7 still not issued", 64'(acq_valid), 64'd0);
    fwd_valid = 1; fwd_line = LINE_W'(32'h1000 >> 3);
    @(negedge clk);
    fwd_valid = 0;
    check("R10 fwd_hit", 64'(fwd_hit), 64'h03);
    check("R10 fwd_data", 64'(fwd_data[15:0]), 64'h9911);
    grant(2'd0, 64'hAB);
    @(negedge clk);
    check("R7 issued after grant", 64'(acq_valid), 64'd1);
    check("R7 issued sid", 64'(acq_sid), 64'd1);
    check("R7 issued mask", 64'(acq_mask), 64'h02);
    check("R7 issued addr", 64'(acq_addr), 64'h1001);
    drain();
  endtask

  task automatic t_load_merge_and_refusals();
    send(0, 1, 32'h2000, 8'h0F, 64'h0, 4'd4);
    check("R1 load accept", 64'(got_acc), 64'd1);
    send(0, 1, 32'h2004, 8'hF0, 64'h0, 4'd5);
    check("R4 merge accept", 64'(got_acc), 64'd1);
    check("R4 merge sid", 64'(got_sid), 64'd0);
    check("R4 acq_mask", 64'(acq_mask), 64'hFF);
    check("R4 acq_store", 64'(acq_store), 64'd0);
    check("R4 acq_addr", 64'(acq_addr), 64'h2000);
    send(1, 1, 32'h2000, 8'h01, 64'h0, 4'd6);
    check("R5 store vs load refused", 64'(got_acc), 64'd0);
    send(0, 0, 32'h2000, 8'h01, 64'h0, 4'd7);
    check("R5 device refused", 64'(got_acc), 64'd0);
    check("R5 refused no change", 64'(acq_mask), 64'hFF);
    drain();
  endtask

  task automatic t_mask_rules();
    send(1, 1, 32'h3000, 8'h01, 64'h5A, 4'd8);
    check("R6 base accept", 64'(got_acc), 64'd1);
    send(1, 1, 32'h3002, 8'h04, 64'h0, 4'd9);
    check("R6 gap union refused", 64'(got_acc), 64'd0);
    send(1, 1, 32'h3801, 8'h06, 64'h0, 4'd10);
    check("R6 misaligned run refused", 64'(got_acc), 64'd0);
    send(1, 0, 32'h3808, 8'h01, 64'h0, 4'd11);
    check("R6 device new line accept", 64'(got_acc), 64'd1);
    check("R6 device sid", 64'(got_sid), 64'd1);
    check("R6 base mask unchanged", 64'(acq_mask), 64'h01);
    drain();
  endtask

  task automatic t_full_and_age();
    send(1, 1, 32'h4000, 8'h01, 64'h0, 4'd1);
    check("R1 fill sid0", 64'(got_sid), 64'd0);
    send(1, 1, 32'h5000, 8'h01, 64'h0, 4'd2);
    check("R1 fill sid1", 64'(got_sid), 64'd1);
    send(1, 1, 32'h6000, 8'h01, 64'h0, 4'd3);
    check("R1 fill sid2", 64'(got_sid), 64'd2);
    send(1, 1, 32'h7000, 8'h01, 64'h0, 4'd4);
    check("R1 fill sid3", 64'(got_sid), 64'd3);
    send(1, 1, 32'h8000, 8'h01, 64'h0, 4'd5);
    check("R2 full refused", 64'(got_acc), 64'd0);
    check("R11 first sid", 64'(acq_sid), 64'd0);
    fire();
    check("R11 next is sid1", 64'(acq_sid), 64'd1);
    grant(2'd0, 64'h77);
    send(1, 1, 32'h9000, 8'h01, 64'h0, 4'd6);
    check("R9 slot reused accept", 64'(got_acc), 64'd1);
    check("R9 slot reused sid", 64'(got_sid), 64'd0);
    fire();
    check("R11 then sid2", 64'(acq_sid), 64'd2);
    fire();
    check("R11 then sid3", 64'(acq_sid), 64'd3);
    fire();
    check("R11 youngest last", 64'(acq_valid), 64'd1);
    check("R11 youngest sid0", 64'(acq_sid), 64'd0);
    grant(2'd1, 64'h1);
    grant(2'd2, 64'h2);
    grant(2'd3, 64'h3);
    drain();
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_store_merge_and_wait();
    t_load_merge_and_refusals();
    t_mask_rules();
    t_full_and_age();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule